// File: doc/BRIEF.md
# AES Decryption Key Derivation Engine

This block turns an AES cipher key into the key that a decryption pass starts from, which is the last round-key material of the forward key schedule. Software uses a small 32-bit register bus. It loads the key words, selects the derivation mode and a key length of 128 or 256 bits, and then sets the enable bit. The engine expands the key one schedule word per clock. It then writes the derived words back over the key registers, raises a completion flag and drops its own enable bit.

The register map works on word addresses:

| Index | Register |
|---|---|
| 0 | Control |
| 1 | Status |
| 4 to 7 | IV registers |
| 8 to 15 | Key registers 0 to 7 |

A key register with a lower number holds a less significant word of the key. The IV registers exist only so that the rules for ignoring them can be enforced. No data path uses them.

Top module: `aes_kd_engine`

## Requirements
- R1: After reset, every register at indices 0 to 15 reads as zero.
- R2: The control register has these fields: bit 0 is enable, bits 2:1 are the mode, bits 5:3 are the chaining selector, bit 6 is the key length (1 selects 256 bits) and bit 7 is a write-only flag-clear bit that reads as 0. A control write that sets enable with mode 01 starts a derivation, and the stored fields read back as written.
- R3: With the 128-bit length, key registers 3 down to 0 receive expanded words 40 to 43 (register 0 gets word 43). Before the run, register 3 holds schedule word 0, the most significant word. Key registers 4 to 7 keep their values.
- R4: With the 256-bit length, key registers 7 down to 0 receive expanded words 52 to 59 (register 0 gets word 59).
- R5: Status bit 0 first reads 1 after the 41st rising edge (128-bit) or the 53rd rising edge (256-bit) that follows the edge capturing the starting write. Until the write-back, the key registers read their previous contents.
- R6: When the derivation completes, hardware clears the enable bit. Mode, chaining and length keep their values.
- R7: The completion flag stays at 1 until a control write with bit 7 set. A control write with bit 7 clear leaves the flag unchanged.
- R8: While a derivation runs, writes to the key registers and to the control register are ignored.
- R9: The chaining selector does not change the derived key for any of its 8 values.
- R10: Writes to the IV registers are stored when the mode is not 01 and ignored when the mode is 01.
- R11: Setting enable with a mode other than 01 starts nothing: the flag stays 0 and the key registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Two situations are hard to reach from the ports.

- **Writes that arrive mid-run.** A key or control write only tests R8 if it lands while the expansion is running. The bench therefore drives the write strobe directly inside the loop that counts cycles after enable. It inserts a key write and a control write a few cycles into the run, then checks that the final result and the latency are both unaffected.
- **The 256-bit schedule.** The 256-bit path has an extra substitution step on every eighth word, and this only shows in the derived key. The sweep alternates the key length on every run while it walks the chaining selector through all eight values. Each result is compared with a schedule model in the bench that builds its S-box from logarithm tables.

// File: rtl/aes_kd_pkg.sv
package aes_kd_pkg;
   localparam int WORD_W = 32;

   // control register bit positions (software contract)
   localparam int CB_EN    = 0;
   localparam int CB_MODE  = 1;
   localparam int CB_CHAIN = 3;
   localparam int CB_KSZ   = 6;
   localparam int CB_CLR   = 7;

   localparam logic [1:0] MODE_KEYDER = 2'b01;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WB} kd_state_e;

   function automatic logic [7:0] gf_xtime(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_xtime(sh);
      end
      return acc;
   endfunction

   // multiplicative inverse as a^254 (zero maps to zero)
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] r;
      logic [7:0] s;
      r = 8'h01;
      s = a;
      for (int i = 1; i < 8; i++) begin
         s = gf_mul(s, s);
         r = gf_mul(r, s);
      end
      return r;
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [7:0] sbox_byte(input logic [7:0] x);
      logic [7:0] b;
      b = gf_inv(x);
      return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
   endfunction
endpackage

// File: rtl/aes_kd_sbox_word.sv
module aes_kd_sbox_word
   import aes_kd_pkg::*;
#(
   parameter int W = WORD_W
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int LANES = W / 8;

   if (W % 8 != 0) begin : g_bad_w
      $error("aes_kd_sbox_word: width must be a whole number of bytes");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dout[8*g +: 8] = sbox_byte(din[8*g +: 8]);
   end
endmodule

// File: rtl/aes_kd_sched.sv
module aes_kd_sched
   import aes_kd_pkg::*;
#(
   parameter int MAX_NK = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         nk8_in,
   input  logic [MAX_NK-1:0][WORD_W-1:0] key_in,
   output logic                         busy,
   output logic                         done,
   output logic [MAX_NK-1:0][WORD_W-1:0] work_out
);
   localparam int IDX_W  = $clog2(MAX_NK);
   localparam int STEP_W = $clog2(4 * (MAX_NK + 7));

   if (MAX_NK != 4 && MAX_NK != 8) begin : g_bad_nk
      $error("aes_kd_sched: MAX_NK must be 4 or 8");
   end

   kd_state_e                      st_q;
   logic [MAX_NK-1:0][WORD_W-1:0]  work_q, work_dn, work_d, load_d;
   logic [STEP_W-1:0]              cnt_q;
   logic [IDX_W-1:0]               pos_q;
   logic [7:0]                     rcon_q;
   logic                           nk8_q;
   int                             nk, nk_ld;
   logic [WORD_W-1:0]              last_w, sub_in, sub_out, temp_w, new_w;
   logic                           pos_zero, pos_wrap, pos_mid;

   always_comb begin
      nk    = (MAX_NK == 8 && nk8_q)  ? 8 : 4;
      nk_ld = (MAX_NK == 8 && nk8_in) ? 8 : 4;
   end

   // newest word of the sliding window feeds the next schedule word
   assign last_w   = work_q[IDX_W'(nk - 1)];
   assign pos_zero = (pos_q == '0);
   assign pos_wrap = (pos_q == IDX_W'(nk - 1));
   assign pos_mid  = nk8_q && (int'(pos_q) == 4);
   assign sub_in   = pos_zero ? {last_w[23:0], last_w[31:24]} : last_w;

   aes_kd_sbox_word #(.W(WORD_W)) u_sub (
      .din  (sub_in),
      .dout (sub_out)
   );

   always_comb begin
      if (pos_zero)     temp_w = sub_out ^ {rcon_q, 24'h000000};
      else if (pos_mid) temp_w = sub_out;
      else              temp_w = last_w;
   end
   assign new_w   = work_q[0] ^ temp_w;
   assign work_dn = work_q >> WORD_W;

   always_comb begin
      for (int j = 0; j < MAX_NK; j++) begin
         if (j == nk - 1)    work_d[j] = new_w;
         else if (j < nk - 1) work_d[j] = work_dn[j];
         else                 work_d[j] = work_q[j];
         // register nk-1-j becomes schedule word j (register 0 is least significant)
         if (j < nk_ld) load_d[j] = key_in[IDX_W'(nk_ld - 1 - j)];
         else           load_d[j] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         work_q <= '0;
         cnt_q  <= '0;
         pos_q  <= '0;
         rcon_q <= 8'h01;
         nk8_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= ST_RUN;
               work_q <= load_d;
               cnt_q  <= '0;
               pos_q  <= '0;
               rcon_q <= 8'h01;
               nk8_q  <= (MAX_NK == 8) && nk8_in;
            end
            ST_RUN: begin
               work_q <= work_d;
               cnt_q  <= cnt_q + 1'b1;
               pos_q  <= pos_wrap ? '0 : pos_q + 1'b1;
               if (pos_zero) rcon_q <= gf_xtime(rcon_q);
               if (cnt_q == STEP_W'(3 * nk + 27)) st_q <= ST_WB;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != ST_IDLE);
   assign done     = (st_q == ST_WB);
   assign work_out = work_q;
endmodule

// File: rtl/aes_kd_engine.sv
module aes_kd_engine
   import aes_kd_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter bit SUPPORT_256 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int KEY_WORDS = 8;
   localparam int IV_WORDS  = 4;
   localparam int MAX_NK    = SUPPORT_256 ? 8 : 4;
   localparam int IDX_W     = $clog2(MAX_NK);

   if (DATA_W != WORD_W) begin : g_bad_data
      $error("aes_kd_engine: DATA_W must equal 32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("aes_kd_engine: ADDR_W must be at least 4");
   end

   logic                              ctrl_en, ksz_q, flag;
   logic [1:0]                        ctrl_mode;
   logic [2:0]                        ctrl_chain;
   logic [KEY_WORDS-1:0][WORD_W-1:0]  key_q;
   logic [IV_WORDS-1:0][WORD_W-1:0]   iv_q;
   logic [MAX_NK-1:0][WORD_W-1:0]     work;
   logic                              busy, kd_done, start;
   logic [3:0]                        idx;
   logic                              in_map, is_ctrl, is_stat, is_iv, is_key;
   int                                nk_top;

   assign idx     = bus_addr[3:0];
   assign in_map  = ((bus_addr >> 4) == '0);
   assign is_ctrl = in_map && (idx == 4'd0);
   assign is_stat = in_map && (idx == 4'd1);
   assign is_iv   = in_map && (idx[3:2] == 2'b01);
   assign is_key  = in_map && idx[3];

   assign start = bus_we && is_ctrl && !busy && bus_wdata[CB_EN]
                  && (bus_wdata[CB_MODE +: 2] == MODE_KEYDER);

   // key-length storage exists only in the variant that supports 256-bit keys
   if (SUPPORT_256) begin : g_ksz_on
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        ksz_q <= 1'b0;
         else if (bus_we && is_ctrl && !busy) ksz_q <= bus_wdata[CB_KSZ];
      end
   end else begin : g_ksz_off
      assign ksz_q = 1'b0;
   end

   assign nk_top = ksz_q ? 8 : 4;

   aes_kd_sched #(.MAX_NK(MAX_NK)) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .nk8_in   (SUPPORT_256 && bus_wdata[CB_KSZ]),
      .key_in   (key_q[MAX_NK-1:0]),
      .busy     (busy),
      .done     (kd_done),
      .work_out (work)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en    <= 1'b0;
         ctrl_mode  <= 2'b00;
         ctrl_chain <= 3'b000;
         flag       <= 1'b0;
      end else if (kd_done) begin
         ctrl_en <= 1'b0;
         flag    <= 1'b1;
      end else if (bus_we && is_ctrl && !busy) begin
         ctrl_en    <= bus_wdata[CB_EN];
         ctrl_mode  <= bus_wdata[CB_MODE +: 2];
         ctrl_chain <= bus_wdata[CB_CHAIN +: 3];
         if (bus_wdata[CB_CLR]) flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (kd_done) begin
         for (int r = 0; r < MAX_NK; r++) begin
            if (r < nk_top) key_q[r] <= work[IDX_W'(nk_top - 1 - r)];
         end
      end else if (bus_we && is_key && !busy) begin
         key_q[idx[2:0]] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          iv_q <= '0;
      else if (bus_we && is_iv && ctrl_mode != MODE_KEYDER) iv_q[idx[1:0]] <= bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      if (is_ctrl)
         bus_rdata[7:0] = {1'b0, ksz_q, ctrl_chain, ctrl_mode, ctrl_en};
      else if (is_stat)
         bus_rdata[0] = flag;
      else if (is_iv)
         bus_rdata = iv_q[idx[1:0]];
      else if (is_key)
         bus_rdata = key_q[idx[2:0]];
   end
endmodule

// File: rtl/aes_kd_checker.sv
module aes_kd_checker (
   input logic         clk,
   input logic         rst_n,
   input logic         bus_we,
   input logic [3:0]   bus_addr,
   input logic [31:0]  bus_wdata,
   input logic         busy,
   input logic         kd_done,
   input logic         ctrl_en,
   input logic         flag,
   input logic [1:0]   ctrl_mode,
   input logic [255:0] key_flat,
   input logic [127:0] iv_flat
);
   logic clr_wr, iv_wr;
   assign clr_wr = bus_we && (bus_addr == 4'd0) && bus_wdata[7] && !busy;
   assign iv_wr  = bus_we && (bus_addr[3:2] == 2'b01);

   assert_keys_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !kd_done) |=> $stable(key_flat));

   assert_ctrl_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !kd_done) |=> $stable(ctrl_mode));

   assert_en_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> !ctrl_en);

   assert_flag_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(busy));

   assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_wr) |=> flag);

   assert_iv_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_wr && ctrl_mode == 2'b01) |=> $stable(iv_flat));

   assert_start_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (ctrl_en && ctrl_mode == 2'b01));
endmodule

bind aes_kd_engine aes_kd_checker u_aes_kd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr[3:0]),
   .bus_wdata (bus_wdata),
   .busy      (busy),
   .kd_done   (kd_done),
   .ctrl_en   (ctrl_en),
   .flag      (flag),
   .ctrl_mode (ctrl_mode),
   .key_flat  (key_q),
   .iv_flat   (iv_q)
);

// File: tb/test_aes_kd_engine.sv
`timescale 1ns/1ps
module test_aes_kd_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [7:0]  alog [0:255];
   logic [7:0]  lg   [0:255];
   logic [31:0] key_w [0:7];
   logic [31:0] exp_w [0:7];
   logic [31:0] sched [0:59];
   logic [31:0] iv_ref [0:3];
   logic [31:0] lcg = 32'h1234_5678;

   always #5 clk = ~clk;

   aes_kd_engine i_aes_kd_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] cw(input bit en, input logic [1:0] mode,
                                      input logic [2:0] chain, input bit ksz, input bit clr);
      return {24'h0, clr, ksz, chain, mode, en};
   endfunction

   function automatic logic [7:0] xt(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] ref_sbox(input logic [7:0] x);
      logic [7:0] v;
      v = (x == 8'h00) ? 8'h00 : alog[(255 - int'(lg[x])) % 255];
      return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
   endfunction

   function automatic logic [31:0] ref_subw(input logic [31:0] w);
      return {ref_sbox(w[31:24]), ref_sbox(w[23:16]), ref_sbox(w[15:8]), ref_sbox(w[7:0])};
   endfunction

   task automatic build_expected(input bit k256);
      int nk = k256 ? 8 : 4;
      int nw = k256 ? 60 : 44;
      logic [7:0] rc = 8'h01;
      logic [31:0] t;
      for (int j = 0; j < nk; j++) sched[j] = key_w[nk - 1 - j];
      for (int i = nk; i < nw; i++) begin
         t = sched[i - 1];
         if (i % nk == 0) begin
            t = ref_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
            rc = xt(rc);
         end else if (nk == 8 && i % 8 == 4) begin
            t = ref_subw(t);
         end
         sched[i] = sched[i - nk] ^ t;
      end
      for (int r = 0; r < 8; r++) exp_w[r] = (r < nk) ? sched[nw - 1 - r] : key_w[r];
   endtask

   task automatic one_run(input int run, input bit k256, input logic [2:0] chain);
      logic [31:0] d;
      int lim = k256 ? 53 : 41;
      int seen_at = -1;
      build_expected(k256);
      for (int r = 0; r < 8; r++) bus_write(4'(8 + r), key_w[r]);
      bus_write(4'd0, cw(0, 2'b01, chain, k256, 0));
      // IV write in derivation mode must be dropped
      bus_write(4'(4 + run % 4), 32'hbad0_0000 | run);
      bus_read(4'(4 + run % 4), d);
      check("R10 iv write ignored in mode 01", d, iv_ref[run % 4]);
      bus_write(4'd0, cw(1, 2'b01, chain, k256, 0));
      for (int c = 1; c <= lim + 3 && seen_at < 0; c++) begin
         @(negedge clk);
         bus_we = 1'b0;
         if (c == 5) begin
            bus_we = 1'b1; bus_addr = 4'd8; bus_wdata = 32'hdead_beef;   // R8 attempt
         end else if (c == 7) begin
            bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = cw(0, 2'b00, 3'd0, 0, 1);
         end else begin
            if (c == 3) begin
               bus_addr = 4'd8;
               #1 check("R5 old key during run", bus_rdata, key_w[0]);
            end
            bus_addr = 4'd1;
            #1 if (bus_rdata[0]) seen_at = c;
         end
      end
      bus_we = 1'b0;
      check("R5 completion latency", 32'(seen_at), 32'(lim));
      for (int r = 0; r < 8; r++) begin
         bus_read(4'(8 + r), d);
         check(k256 ? "R4 256-bit derived key (R9 R8)" : "R3 128-bit derived key (R9 R8)", d, exp_w[r]);
      end
      bus_read(4'd0, d);
      check("R6 enable cleared, fields kept", d, cw(0, 2'b01, chain, k256, 0));
      repeat (5) @(negedge clk);
      bus_write(4'd0, cw(0, 2'b01, chain, k256, 0));
      bus_read(4'd1, d);
      check("R7 flag held without clear", d, 32'h1);
      bus_write(4'd0, cw(0, 2'b01, chain, k256, 1));
      bus_read(4'd1, d);
      check("R7 flag cleared", d, 32'h0);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      alog[0] = 8'h01;
      for (int i = 1; i < 256; i++) alog[i] = alog[i - 1] ^ xt(alog[i - 1]);
      for (int i = 0; i < 256; i++) lg[i] = 8'h00;
      for (int i = 0; i < 255; i++) lg[alog[i]] = 8'(i);

      // known 128-bit vector sanity on the bench model
      key_w[3] = 32'h2b7e1516; key_w[2] = 32'h28aed2a6;
      key_w[1] = 32'habf71588; key_w[0] = 32'h09cf4f3c;
      for (int r = 4; r < 8; r++) key_w[r] = 32'h0;
      build_expected(1'b0);
      check("R3 model reference word 43", exp_w[0], 32'hb6630ca6);
      check("R3 model reference word 40", exp_w[3], 32'hd014f9a8);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int a = 0; a < 16; a++) begin
         bus_read(4'(a), d);
         check("R1 reset value", d, 32'h0);
      end

      for (int i = 0; i < 4; i++) begin
         iv_ref[i] = 32'h1100_0000 * (i + 1) + 32'h55;
         bus_write(4'(4 + i), iv_ref[i]);
         bus_read(4'(4 + i), d);
         check("R10 iv stored outside mode 01", d, iv_ref[i]);
      end

      // R11: enable with another mode starts nothing
      bus_write(4'd8, 32'h0bad_cafe);
      bus_write(4'd0, cw(1, 2'b10, 3'd5, 0, 0));
      bus_read(4'd0, d);
      check("R2 control fields read back", d, cw(1, 2'b10, 3'd5, 0, 0));
      repeat (60) @(negedge clk);
      bus_read(4'd1, d);
      check("R11 no completion in other mode", d, 32'h0);
      bus_read(4'd8, d);
      check("R11 key untouched in other mode", d, 32'h0bad_cafe);
      bus_write(4'd0, cw(0, 2'b00, 3'd0, 0, 0));

      for (int run = 0; run < 16; run++) begin
         if (run == 0) begin
            key_w[3] = 32'h2b7e1516; key_w[2] = 32'h28aed2a6;
            key_w[1] = 32'habf71588; key_w[0] = 32'h09cf4f3c;
            for (int r = 4; r < 8; r++) key_w[r] = 32'h7700_0000 + r;
         end else if (run == 2) begin
            for (int r = 0; r < 8; r++) key_w[r] = 32'h0;
         end else if (run == 5) begin
            for (int r = 0; r < 8; r++) key_w[r] = 32'hffff_ffff;
         end else begin
            for (int r = 0; r < 8; r++) begin
               lcg = lcg * 32'd1664525 + 32'd1013904223;
               key_w[r] = lcg;
            end
         end
         one_run(run, run[0], 3'(run >> 1));
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule